// File: doc/BRIEF.md
# Debug Interface Enable Sequencer

This block decides when a two-wire programming port may take over a device. It watches two external pins: a debug data line, and a debug clock pin that otherwise acts as the chip's reset input. A programmer first holds the data line high long enough to override the reset function of the shared pin. It then toggles the clock pin while the data line stays high. Once enough rising edges have arrived, the port is declared active.

The block runs from a fast internal reference clock. Both pins pass through a two-flop synchronizer, and clock edges are found on the synchronized level. All time windows are counted in reference-clock cycles: the hold time, the deadline for the first edge and the inactivity limit. If the clock pin stays still for too long, the port drops and the pin returns to its reset role. When the port becomes active, the level of the shared pin is captured and held on an output for the device's reset logic.

Top module: `dbg_enable_seq`

## Requirements
- R1: Counting from the clock edge after a pin changes, the synchronized data line reaches the sequencer two reference cycles later. `rstfn_off_o` goes to 1 once the data line has been seen high for HOLD_CYC consecutive cycles. If the data line is driven high just before edge 0, the output is 0 after edge HOLD_CYC and 1 after edge HOLD_CYC+1. A shorter high pulse leaves the output at 0 and restarts the hold count.
- R2: After the override, NEED_EDGES rising edges of the clock pin, each seen while the data line is high, set `link_en_o` to 1. One fewer edge leaves it at 0.
- R3: If no rising edge arrives with the data line high within FIRST_EDGE_CYC cycles of the override, `rstfn_off_o` returns to 0. With the data line driven high just before edge 0, the output is still 1 after edge HOLD_CYC+FIRST_EDGE_CYC and is 0 after edge HOLD_CYC+FIRST_EDGE_CYC+1.
- R4: While edges are being counted or the port is active, IDLE_CYC cycles with no rising edge drop both `link_en_o` and `rstfn_off_o` to 0.
- R5: An inactivity timeout partway through the edge count discards all progress. The data line must again be held for the full hold time, and a full NEED_EDGES edges are needed after that.
- R6: When `link_en_o` rises, the synchronized level of the clock pin is captured into `pin_cap_o`, which is 1 because the enabling edge has just been seen. The output then holds its value whatever the pin does, for as long as the port stays active, and is cleared to 0 when the port drops.
- R7: A rising edge seen while the data line is low during the edge count resets the count to zero. Only edges after that edge count toward NEED_EDGES.
- R8: While `rst_ni` is 0, all three outputs are 0 and the sequencer is idle, with the pin keeping its reset function.
- R9: While the port is active, the level of the data line has no effect on `link_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast internal reference clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| dbg_data_i | input | 1 | Debug data line, asynchronous |
| dbg_clk_i | input | 1 | Debug clock pin shared with the reset function, asynchronous |
| link_en_o | output | 1 | Programming port active |
| rstfn_off_o | output | 1 | Reset function of the shared pin overridden |
| pin_cap_o | output | 1 | Level of the shared pin captured when the port became active |

## Verification
On every cycle, the assertions check these relations: the override only rises after the data line was seen high, and the port only rises on an edge seen with the data line high. The port never stands without the override, and the captured pin level is stable and cleared with the port. The edge count is cleared by a low data line, and a deadline release happens only at the deadline count. The exact latencies, and the edge counts just below and at the threshold with and without a mid-count data drop, can only be shown by the bench's scenarios. So can the restart after a timeout partway through the count, and the fact that the data line is ignored while the port is active.

// File: rtl/dbgen_pkg.sv
package dbgen_pkg;

    // Sequencer phases: waiting for hold, waiting for first edge,
    // counting edges, port active.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2,
        ST_LINK  = 2'd3
    } seq_state_e;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dbgen_sync.sv
module dbgen_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] stg_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stg_d[s] = async_i;
            end else begin : g_next
                always_comb stg_d[s] = stg_q[s-1];
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    stg_q[s] <= '0;
                end else begin
                    stg_q[s] <= stg_d[s];
                end
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/dbgen_rise.sv
module dbgen_rise (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic rise_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign rise_o = level_i & ~prev_q;

    // A held-high pin yields a single-cycle edge pulse.
    AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o); // R2

endmodule

// File: rtl/dbgen_fsm.sv
module dbgen_fsm
    import dbgen_pkg::*;
#(
    parameter int unsigned HOLD_CYC       = 100,
    parameter int unsigned FIRST_EDGE_CYC = 10000,
    parameter int unsigned IDLE_CYC       = 10000,
    parameter int unsigned NEED_EDGES     = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic data_s_i,
    input  logic pin_s_i,
    input  logic pin_rise_i,
    output logic link_en_o,
    output logic rstfn_off_o,
    output logic pin_cap_o
);

    localparam int unsigned MAX_LIM = max3(HOLD_CYC, FIRST_EDGE_CYC, IDLE_CYC);
    localparam int unsigned TW      = $clog2(MAX_LIM + 1);
    localparam int unsigned EW      = $clog2(NEED_EDGES + 1);
    localparam logic [TW-1:0] HOLD_LAST  = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] FIRST_LAST = TW'(FIRST_EDGE_CYC - 1);
    localparam logic [TW-1:0] IDLE_LAST  = TW'(IDLE_CYC - 1);
    localparam logic [EW-1:0] EDGE_LAST  = EW'(NEED_EDGES - 1);

    typedef struct packed {
        seq_state_e      state;
        logic [TW-1:0]   tmr;
        logic [EW-1:0]   edges;
        logic            link;
        logic            rstoff;
        logic            cap;
    } seq_reg_t;

    localparam seq_reg_t SEQ_RESET = '{
        state:  ST_IDLE,
        tmr:    '0,
        edges:  '0,
        link:   1'b0,
        rstoff: 1'b0,
        cap:    1'b0
    };

    seq_reg_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_IDLE: begin
                seq_d.link   = 1'b0;
                seq_d.rstoff = 1'b0;
                seq_d.cap    = 1'b0;
                seq_d.edges  = '0;
                if (data_s_i) begin
                    if (seq_q.tmr == HOLD_LAST) begin
                        seq_d.state  = ST_ARMED;
                        seq_d.tmr    = '0;
                        seq_d.rstoff = 1'b1;
                    end else begin
                        seq_d.tmr = seq_q.tmr + 1'b1;
                    end
                end else begin
                    seq_d.tmr = '0;
                end
            end

            ST_ARMED: begin
                if (pin_rise_i && data_s_i) begin
                    seq_d.tmr   = '0;
                    seq_d.edges = EW'(1);
                    if (NEED_EDGES == 1) begin
                        seq_d.state = ST_LINK;
                        seq_d.link  = 1'b1;
                        seq_d.cap   = pin_s_i;
                        seq_d.edges = '0;
                    end else begin
                        seq_d.state = ST_COUNT;
                    end
                end else if (seq_q.tmr == FIRST_LAST) begin
                    seq_d.state  = ST_IDLE;
                    seq_d.tmr    = '0;
                    seq_d.rstoff = 1'b0;
                end else begin
                    seq_d.tmr = seq_q.tmr + 1'b1;
                end
            end

            ST_COUNT: begin
                if (pin_rise_i) begin
                    seq_d.tmr = '0;
                    if (!data_s_i) begin
                        seq_d.edges = '0;
                    end else if (seq_q.edges == EDGE_LAST) begin
                        seq_d.state = ST_LINK;
                        seq_d.link  = 1'b1;
                        seq_d.cap   = pin_s_i;
                        seq_d.edges = '0;
                    end else begin
                        seq_d.edges = seq_q.edges + 1'b1;
                    end
                end else if (seq_q.tmr == IDLE_LAST) begin
                    seq_d.state  = ST_IDLE;
                    seq_d.tmr    = '0;
                    seq_d.edges  = '0;
                    seq_d.rstoff = 1'b0;
                end else begin
                    seq_d.tmr = seq_q.tmr + 1'b1;
                    if (!data_s_i) begin
                        seq_d.edges = '0;
                    end
                end
            end

            ST_LINK: begin
                if (pin_rise_i) begin
                    seq_d.tmr = '0;
                end else if (seq_q.tmr == IDLE_LAST) begin
                    seq_d.state  = ST_IDLE;
                    seq_d.tmr    = '0;
                    seq_d.link   = 1'b0;
                    seq_d.rstoff = 1'b0;
                    seq_d.cap    = 1'b0;
                end else begin
                    seq_d.tmr = seq_q.tmr + 1'b1;
                end
            end

            default: seq_d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= SEQ_RESET;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign link_en_o   = seq_q.link;
    assign rstfn_off_o = seq_q.rstoff;
    assign pin_cap_o   = seq_q.cap;

    AST_ARM_AFTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(seq_q.rstoff) |-> $past(data_s_i)); // R1

    AST_LINK_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(seq_q.link) |-> $past(pin_rise_i && data_s_i)); // R2

    AST_LINK_NEEDS_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_q.link |-> seq_q.rstoff); // R2

    AST_DEADLINE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(seq_q.rstoff) && $past(seq_q.state == ST_ARMED))
            |-> $past(seq_q.tmr == FIRST_LAST)); // R3

    AST_DROP_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(seq_q.link) |-> !seq_q.rstoff); // R4

    AST_CAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.link && $past(seq_q.link)) |-> $stable(seq_q.cap)); // R6

    AST_CAP_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !seq_q.link |-> !seq_q.cap); // R6

    AST_EDGE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_q.edges <= EDGE_LAST); // R7

    AST_DROP_CLEARS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(seq_q.state == ST_COUNT) && !$past(data_s_i)) |-> (seq_q.edges == '0)); // R7

endmodule

// File: rtl/dbg_enable_seq.sv
module dbg_enable_seq #(
    parameter int unsigned HOLD_CYC       = 100,
    parameter int unsigned FIRST_EDGE_CYC = 10000,
    parameter int unsigned IDLE_CYC       = 10000,
    parameter int unsigned NEED_EDGES     = 16,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic dbg_data_i,
    input  logic dbg_clk_i,
    output logic link_en_o,
    output logic rstfn_off_o,
    output logic pin_cap_o
);

    logic [1:0] pins_s;
    logic       pin_rise;

    dbgen_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({dbg_clk_i, dbg_data_i}),
        .sync_o  (pins_s)
    );

    dbgen_rise u_rise (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (pins_s[1]),
        .rise_o  (pin_rise)
    );

    dbgen_fsm #(
        .HOLD_CYC       (HOLD_CYC),
        .FIRST_EDGE_CYC (FIRST_EDGE_CYC),
        .IDLE_CYC       (IDLE_CYC),
        .NEED_EDGES     (NEED_EDGES)
    ) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .data_s_i    (pins_s[0]),
        .pin_s_i     (pins_s[1]),
        .pin_rise_i  (pin_rise),
        .link_en_o   (link_en_o),
        .rstfn_off_o (rstfn_off_o),
        .pin_cap_o   (pin_cap_o)
    );

endmodule

// File: tb/dbg_enable_seq_tb.sv
module dbg_enable_seq_tb;

    localparam int H  = 20;
    localparam int DL = 50;
    localparam int IC = 40;
    localparam int NE = 16;
    localparam int NV = 5;

    // Vector table: pulses sent, index of pulse with data low (-1 none),
    // expected link_en_o and rstfn_off_o afterwards.
    localparam int V_PULSES [NV] = '{16, 15, 20, 19, 24};
    localparam int V_DROP   [NV] = '{-1, -1,  3,  3, 10};
    localparam int V_EN     [NV] = '{ 1,  0,  1,  0,  0};
    localparam int V_OFF    [NV] = '{ 1,  1,  1,  1,  1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic data = 1'b0;
    logic pin = 1'b0;
    logic en, off, cap;
    int   checks = 0;
    int   errors = 0;

    always #5 clk = ~clk;

    dbg_enable_seq #(
        .HOLD_CYC       (H),
        .FIRST_EDGE_CYC (DL),
        .IDLE_CYC       (IC),
        .NEED_EDGES     (NE)
    ) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .dbg_data_i  (data),
        .dbg_clk_i   (pin),
        .link_en_o   (en),
        .rstfn_off_o (off),
        .pin_cap_o   (cap)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        data  = 1'b0;
        pin   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse(input int n, input int drop);
        for (int i = 0; i < n; i++) begin
            if (i == drop) begin
                @(negedge clk);
                data = 1'b0;
            end
            @(negedge clk);
            pin = 1'b1;
            repeat (4) @(negedge clk);
            pin = 1'b0;
            repeat (4) @(negedge clk);
            if (i == drop) data = 1'b1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R8: outputs cleared while in reset
        repeat (2) @(negedge clk);
        chk("R8 reset en", en, 1'b0);
        chk("R8 reset off", off, 1'b0);
        chk("R8 reset cap", cap, 1'b0);

        // Table walk: R2 threshold, R7 drop resets count
        for (int v = 0; v < NV; v++) begin
            do_reset();
            @(negedge clk);
            data = 1'b1;
            wait_cyc(H + 5);
            pulse(V_PULSES[v], V_DROP[v]);
            wait_cyc(6);
            chk($sformatf("R2/R7 vec%0d en", v), en, V_EN[v] != 0);
            chk($sformatf("R2/R7 vec%0d off", v), off, V_OFF[v] != 0);
        end

        // R1: short hold does nothing
        do_reset();
        @(negedge clk);
        data = 1'b1;
        wait_cyc(10);
        @(negedge clk);
        data = 1'b0;
        wait_cyc(20);
        chk("R1 short hold off", off, 1'b0);

        // R1 exact hold latency, then R3 deadline
        @(negedge clk);
        data = 1'b1;
        wait_cyc(H + 1);
        chk("R1 before hold off", off, 1'b0);
        wait_cyc(1);
        chk("R1 at hold off", off, 1'b1);
        wait_cyc(DL - 1);
        chk("R3 before deadline off", off, 1'b1);
        wait_cyc(1);
        chk("R3 at deadline off", off, 1'b0);

        // R6 capture and hold, R9 data ignored, R4 inactivity
        do_reset();
        @(negedge clk);
        data = 1'b1;
        wait_cyc(H + 5);
        pulse(NE, -1);
        wait_cyc(4);
        chk("R2 enabled", en, 1'b1);
        chk("R6 captured", cap, 1'b1);
        wait_cyc(20);
        chk("R6 cap held with pin low", cap, 1'b1);
        @(negedge clk);
        data = 1'b0;
        pulse(2, -1);
        wait_cyc(3);
        chk("R9 data low ignored", en, 1'b1);
        wait_cyc(IC + 10);
        chk("R4 idle en", en, 1'b0);
        chk("R4 idle off", off, 1'b0);
        chk("R6 cap cleared", cap, 1'b0);

        // R5: timeout partway restarts the whole sequence
        do_reset();
        @(negedge clk);
        data = 1'b1;
        wait_cyc(H + 5);
        pulse(8, -1);
        wait_cyc(42);
        chk("R4/R5 mid timeout off", off, 1'b0);
        wait_cyc(20);
        chk("R5 re-armed off", off, 1'b1);
        pulse(8, -1);
        wait_cyc(4);
        chk("R5 old edges discarded", en, 1'b0);
        pulse(8, -1);
        wait_cyc(4);
        chk("R5 full count enables", en, 1'b1);

        // R8: system reset while active
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R8 reset drops en", en, 1'b0);
        chk("R8 reset drops off", off, 1'b0);
        chk("R8 reset drops cap", cap, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule